// File: doc/BRIEF.md
# Peripheral module standby controller

This block lets software halt six on-chip peripherals one by one, independently of any chip-wide power-down. An 8-bit control register holds one stop bit per peripheral. When a stop bit is 1, the controller holds that peripheral in synchronous reset, so its registers return to their initial values. It also masks the peripheral's interrupt request. Reads of the peripheral's address block return 0xFF, and writes to that block are dropped. The controller sits on a simple peripheral bus that carries an address, read and write strobes, write data and a master flag that tells the CPU from the DMA controller.

Only the CPU may change the control register; the DMA master may read it. Two of the stop bits halt units that can own the system bus: bit 2 is the DMA controller and bit 1 is the refresh controller. Stopping such a unit while it is requesting the bus would leave bus arbitration undefined. The controller therefore defers that stop, raises a hazard flag, and applies the stop once the request drops.

Top module: `mod_halt_ctrl`

## Requirements
- R1: After reset all stop outputs and both hazard flags are 0, and a read of the control register (address 0xF0) returns 0x00.
- R2: A CPU write to address 0xF0 loads bit k of the write data into stop bit k (k = 0 to 5). The stop outputs keep their old value during the write cycle and change in the following cycle. Bits 7 and 6 read back as 0.
- R3: A write to 0xF0 with the DMA master flag set (busDma = 1) leaves every stop bit unchanged, and a DMA read of 0xF0 returns the current stop bits.
- R4: A read in the address block of a stopped peripheral k (address bits 7:4 equal k) returns 0xFF and does not raise that peripheral's read enable.
- R5: A write in the address block of a stopped peripheral does not raise its write enable.
- R6: An access to the block of a running peripheral k raises only perRd[k] or perWr[k], and a read returns that peripheral's byte perRdData[8k+7:8k]. A read of an unmapped address returns 0x00.
- R7: The interrupt output of each peripheral is forced to 0 while its stop bit is 1 and follows the interrupt input otherwise.
- R8: A CPU write of 1 to stop bit 2 while unitBusReq[1] is 1, or to stop bit 1 while unitBusReq[0] is 1, leaves that stop bit at 0 and sets hazardFlag[1] or hazardFlag[0] in the next cycle. The other bits of the write take effect normally. The deferred stop bit is set at the clock edge of the first cycle in which the request is 0.
- R9: A CPU write to 0xF0 that is not hazardous for a guarded unit clears that unit's hazard flag and cancels its deferred stop. This includes a write in the very cycle its request drops.
- R10: Clearing a stop bit releases the peripheral in the cycle after the write, and access to its registers works from that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Bus address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busDma | input | 1 | Master flag: 1 = DMA master, 0 = CPU |
| busRdata | output | 8 | Read data (combinational) |
| perRdData | input | 48 | Read bytes from the six peripherals, peripheral k in bits 8k+7:8k |
| perRd | output | 6 | Per-peripheral read enable |
| perWr | output | 6 | Per-peripheral write enable |
| unitBusReq | input | 2 | Bus requests: bit 0 refresh controller, bit 1 DMA controller |
| modStop | output | 6 | Per-peripheral stop and synchronous reset |
| irqIn | input | 6 | Raw peripheral interrupt requests |
| irqOut | output | 6 | Masked interrupt requests |
| hazardFlag | output | 2 | Sticky deferral flags: bit 0 refresh, bit 1 DMA |

## Verification
Two events can meet in one cycle: a deferred stop maturing because the unit's bus request drops, and a new CPU write to the control register. The bench provokes this by deferring a DMA-controller stop and then, in one drive, dropping the request and writing 0 to that bit. It expects the write to win, so the stop output stays 0 over the following cycles and the flag clears. It also writes the bit to 1 in a cycle where the request is already low, and expects the stop to be applied directly.

// File: rtl/msc_pkg.sv
package msc_pkg;
  localparam int MOD_N = 6;

  typedef struct packed {
    logic             isRd;
    logic             isWr;
    logic             ctrlRd;
    logic             ctrlWr;
    logic [MOD_N-1:0] perHit;
  } busStrobe_t;
endpackage

// File: rtl/msc_decode.sv
module msc_decode
  import msc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          BLK_SHIFT = 4,
  parameter logic [7:0]  CTRL_ADDR = 8'hF0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              dma,
  output busStrobe_t        strb
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  logic ctrlHit;
  assign ctrlHit = (addr == ADDR_W'(CTRL_ADDR));

  assign strb.isRd   = rd;
  assign strb.isWr   = wr;
  assign strb.ctrlRd = rd & ctrlHit;
  // only the CPU master may change the control register
  assign strb.ctrlWr = wr & ctrlHit & ~dma;

  for (genvar k = 0; k < MOD_N; k++) begin : g_hit
    assign strb.perHit[k] = (addr[ADDR_W-1:BLK_SHIFT] == BLK_W'(k));
  end
endmodule

// File: rtl/msc_guard.sv
module msc_guard (
  input  logic clk,
  input  logic rstN,
  input  logic cpuWr,
  input  logic wBit,
  input  logic busReq,
  input  logic curStop,
  output logic stopNext,
  output logic flag
);
  logic pending;
  logic hazard;
  logic mature;

  assign hazard = cpuWr & wBit & busReq & ~curStop;
  assign mature = pending & ~busReq;

  always_comb begin
    if (cpuWr)       stopNext = hazard ? curStop : wBit;
    else if (mature) stopNext = 1'b1;
    else             stopNext = curStop;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      flag    <= 1'b0;
    end else if (cpuWr) begin
      pending <= hazard;
      flag    <= hazard;
    end else if (mature) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/msc_core.sv
module msc_core
  import msc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int REF_BIT = 1,
  parameter int DMA_BIT = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  busStrobe_t              strb,
  input  logic [MOD_N-1:0]        wBits,
  input  logic [1:0]              unitBusReq,
  input  logic [MOD_N*DATA_W-1:0] perRdData,
  input  logic [MOD_N-1:0]        irqIn,
  output logic [DATA_W-1:0]       rdata,
  output logic [MOD_N-1:0]        perRd,
  output logic [MOD_N-1:0]        perWr,
  output logic [MOD_N-1:0]        modStop,
  output logic [MOD_N-1:0]        irqOut,
  output logic [1:0]              hazardFlag
);
  logic [MOD_N-1:0] stopReg;
  logic [MOD_N-1:0] stopNext;

  for (genvar k = 0; k < MOD_N; k++) begin : g_bit
    if (k == REF_BIT || k == DMA_BIT) begin : g_guarded
      localparam int GI = (k == DMA_BIT) ? 1 : 0;
      msc_guard u_guard (
        .clk     (clk),
        .rstN    (rstN),
        .cpuWr   (strb.ctrlWr),
        .wBit    (wBits[k]),
        .busReq  (unitBusReq[GI]),
        .curStop (stopReg[k]),
        .stopNext(stopNext[k]),
        .flag    (hazardFlag[GI])
      );
    end else begin : g_plain
      assign stopNext[k] = strb.ctrlWr ? wBits[k] : stopReg[k];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stopReg <= '0;
    else       stopReg <= stopNext;
  end

  always_comb begin
    rdata = '0;
    if (strb.ctrlRd) begin
      rdata = DATA_W'(stopReg);
    end else if (strb.isRd) begin
      for (int k = 0; k < MOD_N; k++) begin
        if (strb.perHit[k])
          rdata = stopReg[k] ? '1 : perRdData[k*DATA_W +: DATA_W];
      end
    end
  end

  assign perRd   = strb.isRd ? (strb.perHit & ~stopReg) : '0;
  assign perWr   = strb.isWr ? (strb.perHit & ~stopReg) : '0;
  assign modStop = stopReg;
  assign irqOut  = irqIn & ~stopReg;
endmodule

// File: rtl/mod_halt_ctrl.sv
module mod_halt_ctrl
  import msc_pkg::*;
#(
  parameter int         ADDR_W    = 8,
  parameter int         DATA_W    = 8,
  parameter int         BLK_SHIFT = 4,
  parameter logic [7:0] CTRL_ADDR = 8'hF0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busRd,
  input  logic                    busWr,
  input  logic [DATA_W-1:0]       busWdata,
  input  logic                    busDma,
  output logic [DATA_W-1:0]       busRdata,
  input  logic [MOD_N*DATA_W-1:0] perRdData,
  output logic [MOD_N-1:0]        perRd,
  output logic [MOD_N-1:0]        perWr,
  input  logic [1:0]              unitBusReq,
  output logic [MOD_N-1:0]        modStop,
  input  logic [MOD_N-1:0]        irqIn,
  output logic [MOD_N-1:0]        irqOut,
  output logic [1:0]              hazardFlag
);
  busStrobe_t strb;
  logic       unusedHiBits;

  assign unusedHiBits = ^busWdata[DATA_W-1:MOD_N];

  msc_decode #(
    .ADDR_W   (ADDR_W),
    .BLK_SHIFT(BLK_SHIFT),
    .CTRL_ADDR(CTRL_ADDR)
  ) u_decode (
    .addr(busAddr),
    .rd  (busRd),
    .wr  (busWr),
    .dma (busDma),
    .strb(strb)
  );

  msc_core #(
    .DATA_W(DATA_W)
  ) u_core (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wBits     (busWdata[MOD_N-1:0]),
    .unitBusReq(unitBusReq),
    .perRdData (perRdData),
    .irqIn     (irqIn),
    .rdata     (busRdata),
    .perRd     (perRd),
    .perWr     (perWr),
    .modStop   (modStop),
    .irqOut    (irqOut),
    .hazardFlag(hazardFlag)
  );
endmodule

// File: rtl/msc_checker.sv
module msc_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  busAddr,
  input logic        busRd,
  input logic        busWr,
  input logic [7:0]  busWdata,
  input logic        busDma,
  input logic [7:0]  busRdata,
  input logic [47:0] perRdData,
  input logic [5:0]  perRd,
  input logic [5:0]  perWr,
  input logic [1:0]  unitBusReq,
  input logic [5:0]  modStop,
  input logic [5:0]  irqIn,
  input logic [5:0]  irqOut,
  input logic [1:0]  hazardFlag
);
  logic [5:0] hitVec;
  logic       ctrlSel;
  logic       unusedIn;

  assign unusedIn = ^{perRdData, perRd, irqIn};
  assign ctrlSel  = (busAddr == 8'hF0);

  always_comb begin
    for (int k = 0; k < 6; k++) hitVec[k] = (busAddr[7:4] == 4'(k));
  end

  // R2
  cpu_write_lands_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busDma && ctrlSel && unitBusReq == 2'b00)
      |=> (modStop == $past(busWdata[5:0])));

  // R3
  dma_write_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busDma && ctrlSel)
      |=> ($stable(modStop[0]) && $stable(modStop[5:3])));

  // R4
  stopped_read_ff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && |(hitVec & modStop)) |-> (busRdata == 8'hFF));

  // R5
  stopped_write_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((perWr & modStop) == 6'b0));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOut & modStop) == 6'b0));

  // R8
  dma_stop_deferred_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !busDma && ctrlSel && busWdata[2] && unitBusReq[1] && !modStop[2])
      |=> (!modStop[2] && hazardFlag[1]));
endmodule

bind mod_halt_ctrl msc_checker u_chk (.*);

// File: tb/sim_mod_halt_ctrl.sv
`timescale 1ns/1ps
module sim_mod_halt_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busWdata = '0;
  logic        busDma = 1'b0;
  logic [7:0]  busRdata;
  logic [47:0] perRdData;
  logic [5:0]  perRd, perWr, modStop, irqOut;
  logic [1:0]  unitBusReq = '0;
  logic [5:0]  irqIn = '0;
  logic [1:0]  hazardFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  for (genvar k = 0; k < 6; k++) begin : g_pd
    assign perRdData[k*8 +: 8] = 8'h10 + 8'(k);
  end

  mod_halt_ctrl u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input bit rd, input bit wr,
                       input logic [7:0] d, input bit dma);
    @(posedge clk); #1;
    busAddr = a; busRd = rd; busWr = wr; busWdata = d; busDma = dma;
  endtask

  task automatic idle();
    drive(8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic rdExp(input logic [7:0] a, input bit dma, input logic [7:0] e,
                       input string tag);
    drive(a, 1'b1, 1'b0, 8'h00, dma);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // scoreboard monitor: compares read data mid-cycle
  always @(negedge clk) begin
    if (busRd && expQ.size() > 0) begin
      automatic logic [7:0] e = expQ.pop_front();
      automatic string t = tagQ.pop_front();
      check(busRdata == e, t, busRdata, e);
    end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(modStop == 6'h00, "R1 stop after reset", modStop, 0);
    check(hazardFlag == 2'b00, "R1 flags after reset", hazardFlag, 0);
    rdExp(8'hF0, 1'b0, 8'h00, "R1 ctrl readback after reset");

    // running peripherals
    rdExp(8'h32, 1'b0, 8'h13, "R6 read running periph 3");
    @(negedge clk); check(perRd == 6'b001000, "R6 perRd", perRd, 6'b001000);
    drive(8'h45, 1'b0, 1'b1, 8'hAA, 1'b0);
    @(negedge clk); check(perWr == 6'b010000, "R6 perWr", perWr, 6'b010000);
    rdExp(8'h80, 1'b0, 8'h00, "R6 unmapped read");

    // stop all
    drive(8'hF0, 1'b0, 1'b1, 8'hFF, 1'b0);
    @(negedge clk); check(modStop == 6'h00, "R2 no change in write cycle", modStop, 0);
    idle();
    @(negedge clk); check(modStop == 6'h3F, "R2 stop next cycle", modStop, 6'h3F);
    rdExp(8'hF0, 1'b0, 8'h3F, "R2 bits 7:6 read 0");
    rdExp(8'h32, 1'b0, 8'hFF, "R4 stopped read FF");
    @(negedge clk); check(perRd == 6'b0, "R4 no perRd", perRd, 0);
    drive(8'h45, 1'b0, 1'b1, 8'h55, 1'b0);
    @(negedge clk); check(perWr == 6'b0, "R5 no perWr", perWr, 0);
    irqIn = 6'h3F;
    @(negedge clk); check(irqOut == 6'h00, "R7 irq masked", irqOut, 0);

    // release all
    drive(8'hF0, 1'b0, 1'b1, 8'h00, 1'b0);
    @(negedge clk); check(modStop == 6'h3F, "R10 held in write cycle", modStop, 6'h3F);
    rdExp(8'h32, 1'b0, 8'h13, "R10 access back next cycle");
    @(negedge clk); check(modStop == 6'h00, "R10 released", modStop, 0);
    check(irqOut == 6'h3F, "R7 irq passes", irqOut, 6'h3F);

    // DMA master write protection
    drive(8'hF0, 1'b0, 1'b1, 8'h09, 1'b1);
    idle();
    @(negedge clk); check(modStop == 6'h00, "R3 dma write dropped", modStop, 0);
    drive(8'hF0, 1'b0, 1'b1, 8'h09, 1'b0);
    rdExp(8'hF0, 1'b1, 8'h09, "R3 dma read of ctrl");

    // DMA controller hazard
    unitBusReq = 2'b10;
    drive(8'hF0, 1'b0, 1'b1, 8'h0D, 1'b0);
    idle();
    @(negedge clk);
    check(modStop == 6'h09, "R8 bit2 deferred", modStop, 6'h09);
    check(hazardFlag == 2'b10, "R8 dma flag set", hazardFlag, 2'b10);
    idle();
    @(negedge clk); check(modStop == 6'h09, "R8 still deferred", modStop, 6'h09);
    @(posedge clk); #1 unitBusReq = 2'b00;
    @(negedge clk); check(modStop == 6'h09, "R8 not yet applied", modStop, 6'h09);
    @(negedge clk); check(modStop == 6'h0D, "R8 applied after drop", modStop, 6'h0D);
    check(hazardFlag == 2'b10, "R8 flag sticky", hazardFlag, 2'b10);
    drive(8'hF0, 1'b0, 1'b1, 8'h0D, 1'b0);
    idle();
    @(negedge clk); check(hazardFlag == 2'b00, "R9 flag cleared by write", hazardFlag, 0);

    // refresh hazard then cancel
    unitBusReq = 2'b01;
    drive(8'hF0, 1'b0, 1'b1, 8'h0F, 1'b0);
    idle();
    @(negedge clk);
    check(modStop == 6'h0D, "R8 bit1 deferred", modStop, 6'h0D);
    check(hazardFlag == 2'b01, "R8 refresh flag", hazardFlag, 2'b01);
    drive(8'hF0, 1'b0, 1'b1, 8'h0D, 1'b0);
    idle();
    unitBusReq = 2'b00;
    @(negedge clk); check(hazardFlag == 2'b00, "R9 cancel clears flag", hazardFlag, 0);
    idle(); idle();
    @(negedge clk); check(modStop == 6'h0D, "R9 cancelled stop stays off", modStop, 6'h0D);

    // write meets maturing deferral in one cycle
    drive(8'hF0, 1'b0, 1'b1, 8'h00, 1'b0);
    unitBusReq = 2'b10;
    drive(8'hF0, 1'b0, 1'b1, 8'h04, 1'b0);
    idle();
    @(negedge clk); check(hazardFlag == 2'b10, "R8 deferral armed", hazardFlag, 2'b10);
    @(posedge clk); #1
    busAddr = 8'hF0; busWr = 1'b1; busWdata = 8'h00; unitBusReq = 2'b00;
    idle(); idle();
    @(negedge clk);
    check(modStop == 6'h00, "R9 write wins over maturing stop", modStop, 0);
    check(hazardFlag == 2'b00, "R9 flag cleared", hazardFlag, 0);
    drive(8'hF0, 1'b0, 1'b1, 8'h04, 1'b0);
    idle();
    @(negedge clk); check(modStop == 6'h04, "R8 direct stop with req low", modStop, 6'h04);

    idle(); idle();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule